// File: doc/BRIEF.md
# Infrared receive frame address filter

This block sits between the byte decoder of an infrared serial receiver and its receive FIFO. It does two jobs. First, it conditions the raw receive pin before the demodulator sees it. The pin can be inverted or passed straight through, and inversion is the default when the control input is left low, because optical transceivers usually deliver an inverted line. The line is also held at its idle level whenever reception is disabled or the local transmitter is active.

Second, the block watches the decoded frame bytes, each marked with start and end flags. It treats the first byte of every frame as the frame's address. That byte is compared against two programmable 8-bit addresses, and each comparator has its own enable. With both comparators off, every frame passes. Once the decision is made on the address byte, it governs all bytes up to the end flag.

A frame that is cut short, either by blanking or by a fresh start flag, ends with a discard pulse. The FIFO uses that pulse to drop the partial frame it already holds. Bytes of a partial frame never end up in the FIFO as if they were a complete frame.

Top module: `ir_rx_addr_filter`

## Requirements
- R1: While reset is asserted, and until the first input is accepted after reset, `fifo_wr` and `fifo_discard` are 0 and `rx_line` is 1 (idle).
- R2: When neither `cfg_rx_disable` nor `tx_active` is set, `rx_line` equals `~rx_pin` one cycle later if `cfg_rx_passthru` is 0, and equals `rx_pin` one cycle later if it is 1.
- R3: While `cfg_rx_disable` or `tx_active` is 1, `rx_line` is driven to 1 one cycle later, whatever the pin does.
- R4: With `cfg_match_en` = 2'b00, every byte of every frame is written: `fifo_wr` pulses one cycle after each input byte, `fifo_data` carries that byte, and `fifo_last` is 1 only on the byte flagged `in_eof`.
- R5: With `cfg_match_en` = 2'b01, a frame is written only if its address byte (the byte flagged `in_sof`) equals `cfg_addr1`.
- R6: With `cfg_match_en` = 2'b10, a frame is written only if its address byte equals `cfg_addr2`.
- R7: With `cfg_match_en` = 2'b11, a frame is written if its address byte equals either address.
- R8: A rejected frame produces no write strobe for any of its bytes, including later bytes that happen to equal a programmed address. The decision taken on the address byte holds until the end flag.
- R9: Valid bytes that arrive outside a frame (no start flag seen since the last end) produce no write.
- R10: If `cfg_rx_disable` or `tx_active` rises during an accepted frame, `fifo_discard` pulses once one cycle later. No further bytes of that frame are written, even after blanking ends.
- R11: A frame whose start flag arrives while reception is blanked is dropped in full.
- R12: A start flag that arrives inside an accepted frame pulses `fifo_discard` and begins a new frame. That new frame is judged on its own address byte, and its write may occur in the same cycle as the discard pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_pin | input | 1 | Raw receive pin from the optical transceiver |
| rx_line | output | 1 | Conditioned receive line to the demodulator |
| cfg_rx_passthru | input | 1 | 0: invert the pin (default); 1: pass it unchanged |
| cfg_rx_disable | input | 1 | 1: receive input off |
| tx_active | input | 1 | Local transmitter busy; blanks reception |
| cfg_match_en | input | 2 | Bit 0 enables address 1 compare, bit 1 enables address 2 compare |
| cfg_addr1 | input | DATA_W | Address 1 |
| cfg_addr2 | input | DATA_W | Address 2 |
| in_valid | input | 1 | Decoded byte valid |
| in_sof | input | 1 | Byte is the first of a frame (address byte) |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | DATA_W | Decoded byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | FIFO write data |
| fifo_last | output | 1 | Written byte closes the frame |
| fifo_discard | output | 1 | Drop the partially written current frame |

## Verification
The hardest situations to reach from the ports are the interrupted frames. These include a blanking pulse that lands on a middle byte of a frame that was accepted rather than rejected, and a start flag that arrives before the previous frame's end flag. Directed sequences place a `tx_active` pulse and a stray start flag exactly inside accepted frames. A long random run then draws address bytes mostly from the two programmed values and flips the blanking controls with low probability on any byte, so these collisions recur under all four enable settings.

// File: rtl/ir_filt_pkg.sv
package ir_filt_pkg;
  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_PASS = 2'd1,
    FR_SKIP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/ir_rx_line_cond.sv
module ir_rx_line_cond #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic passthru_i,
  input  logic block_i,
  output logic line_o
);
  logic line_n;
  logic line_q;

  always_comb begin
    if (block_i)         line_n = IDLE_LVL;
    else if (passthru_i) line_n = pin_i;
    else                 line_n = ~pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= IDLE_LVL;
    else        line_q <= line_n;
  end

  assign line_o = line_q;
endmodule

// File: rtl/ir_addr_match.sv
module ir_addr_match #(
  parameter int DATA_W   = 8,
  parameter int NUM_ADDR = 2
) (
  input  logic [DATA_W-1:0]          byte_i,
  input  logic [NUM_ADDR*DATA_W-1:0] addr_i,
  input  logic [NUM_ADDR-1:0]        en_i,
  output logic                       accept_o
);
  logic [NUM_ADDR-1:0] hit;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
    assign hit[g] = en_i[g] && (byte_i == addr_i[g*DATA_W +: DATA_W]);
  end

  // all comparators off: open filter
  assign accept_o = (en_i == '0) || (|hit);
endmodule

// File: rtl/ir_frame_gate.sv
module ir_frame_gate
  import ir_filt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              accept_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              discard_o
);
  fr_state_e         state_q, state_n;
  logic              wr_q, wr_n;
  logic              last_q, last_n;
  logic              disc_q, disc_n;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  always_comb begin
    state_n = state_q;
    wr_n    = 1'b0;
    last_n  = 1'b0;
    disc_n  = 1'b0;
    if (block_i) begin
      disc_n  = (state_q == FR_PASS);
      state_n = FR_HUNT;
    end else if (valid_i) begin
      if (sof_i) begin
        disc_n = (state_q == FR_PASS);
        wr_n   = accept_i;
        last_n = accept_i && eof_i;
        if (eof_i)         state_n = FR_HUNT;
        else if (accept_i) state_n = FR_PASS;
        else               state_n = FR_SKIP;
      end else begin
        if (state_q == FR_PASS) begin
          wr_n   = 1'b1;
          last_n = eof_i;
        end
        if (eof_i && state_q != FR_HUNT) state_n = FR_HUNT;
      end
    end
  end

  assign data_en = wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_HUNT;
      wr_q    <= 1'b0;
      last_q  <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      wr_q    <= wr_n;
      last_q  <= last_n;
      disc_q  <= disc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_i;
  end

  assign wr_o      = wr_q;
  assign data_o    = data_q;
  assign last_o    = last_q;
  assign discard_o = disc_q;
endmodule

// File: rtl/ir_rx_addr_filter.sv
module ir_rx_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  output logic              rx_line,
  input  logic              cfg_rx_passthru,
  input  logic              cfg_rx_disable,
  input  logic              tx_active,
  input  logic [1:0]        cfg_match_en,
  input  logic [DATA_W-1:0] cfg_addr1,
  input  logic [DATA_W-1:0] cfg_addr2,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_last,
  output logic              fifo_discard
);
  localparam int NUM_ADDR = 2;
  localparam int RST_STG  = 2;

  logic [RST_STG-1:0]        rst_sync_q;
  logic                      rst_sync_n;
  logic                      rx_block;
  logic                      addr_ok;
  logic [NUM_ADDR*DATA_W-1:0] addr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STG-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[RST_STG-1];

  assign rx_block = cfg_rx_disable | tx_active;
  assign addr_vec = {cfg_addr2, cfg_addr1};

  ir_rx_line_cond #(.IDLE_LVL(1'b1)) u_line (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_i      (rx_pin),
    .passthru_i (cfg_rx_passthru),
    .block_i    (rx_block),
    .line_o     (rx_line)
  );

  ir_addr_match #(.DATA_W(DATA_W), .NUM_ADDR(NUM_ADDR)) u_match (
    .byte_i   (in_data),
    .addr_i   (addr_vec),
    .en_i     (cfg_match_en),
    .accept_o (addr_ok)
  );

  ir_frame_gate #(.DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .block_i   (rx_block),
    .valid_i   (in_valid),
    .sof_i     (in_sof),
    .eof_i     (in_eof),
    .data_i    (in_data),
    .accept_i  (addr_ok),
    .wr_o      (fifo_wr),
    .data_o    (fifo_data),
    .last_o    (fifo_last),
    .discard_o (fifo_discard)
  );
endmodule

// File: rtl/ir_rx_addr_filter_chk.sv
module ir_rx_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_pin,
  input logic              rx_line,
  input logic              cfg_rx_passthru,
  input logic              cfg_rx_disable,
  input logic              tx_active,
  input logic [1:0]        cfg_match_en,
  input logic [DATA_W-1:0] cfg_addr1,
  input logic [DATA_W-1:0] cfg_addr2,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [DATA_W-1:0] in_data,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic              fifo_last,
  input logic              fifo_discard
);
  logic blk;
  assign blk = cfg_rx_disable | tx_active;

  p_line_pol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blk) |-> rx_line == ($past(rx_pin) ^ !$past(cfg_rx_passthru)));

  p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blk) |-> rx_line);

  p_open_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !blk && cfg_match_en == 2'b00)
      |=> fifo_wr && fifo_data == $past(in_data) && fifo_last == $past(in_eof));

  p_reject_a1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && cfg_match_en == 2'b01 && in_data != cfg_addr1) |=> !fifo_wr);

  p_reject_a2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && cfg_match_en == 2'b10 && in_data != cfg_addr2) |=> !fifo_wr);

  p_wr_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(in_valid) && !$past(blk));

  p_blank_no_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blk) |-> !fifo_wr && !fifo_last);

  p_discard_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_discard |-> $past(blk) || ($past(in_valid) && $past(in_sof)));

  p_last_with_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_last |-> fifo_wr);
endmodule

bind ir_rx_addr_filter ir_rx_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .rx_pin          (rx_pin),
  .rx_line         (rx_line),
  .cfg_rx_passthru (cfg_rx_passthru),
  .cfg_rx_disable  (cfg_rx_disable),
  .tx_active       (tx_active),
  .cfg_match_en    (cfg_match_en),
  .cfg_addr1       (cfg_addr1),
  .cfg_addr2       (cfg_addr2),
  .in_valid        (in_valid),
  .in_sof          (in_sof),
  .in_eof          (in_eof),
  .in_data         (in_data),
  .fifo_wr         (fifo_wr),
  .fifo_data       (fifo_data),
  .fifo_last       (fifo_last),
  .fifo_discard    (fifo_discard)
);

// File: tb/test_ir_rx_addr_filter.sv
`timescale 1ns/1ps
module test_ir_rx_addr_filter;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_pin, rx_line;
  logic          cfg_rx_passthru, cfg_rx_disable, tx_active;
  logic [1:0]    cfg_match_en;
  logic [DW-1:0] cfg_addr1, cfg_addr2;
  logic          in_valid, in_sof, in_eof;
  logic [DW-1:0] in_data;
  logic          fifo_wr, fifo_last, fifo_discard;
  logic [DW-1:0] fifo_data;

  int checks = 0;
  int errors = 0;
  int ms = 0;       // bench frame model: 0 none, 1 passing, 2 skipping
  bit done = 1'b0;

  always #10 clk = ~clk;

  ir_rx_addr_filter #(.DATA_W(DW)) i_ir_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_line(rx_line),
    .cfg_rx_passthru(cfg_rx_passthru), .cfg_rx_disable(cfg_rx_disable),
    .tx_active(tx_active), .cfg_match_en(cfg_match_en),
    .cfg_addr1(cfg_addr1), .cfg_addr2(cfg_addr2),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_discard(fifo_discard)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_accept(input logic [DW-1:0] a);
    if (cfg_match_en == 2'b00) return 1'b1;
    return (cfg_match_en[0] && a == cfg_addr1) || (cfg_match_en[1] && a == cfg_addr2);
  endfunction

  // one input cycle: drive after negedge, check at the next negedge
  task automatic step(input logic v, s, e, input logic [DW-1:0] d, input string tag);
    bit blk, ew, el, edisc, acc, eline;
    int ms_n;
    in_valid = v; in_sof = s; in_eof = e; in_data = d;
    blk = cfg_rx_disable | tx_active;
    ew = 0; el = 0; edisc = 0; ms_n = ms;
    if (blk) begin
      edisc = (ms == 1); ms_n = 0;
    end else if (v) begin
      if (s) begin
        edisc = (ms == 1);
        acc = exp_accept(d);
        ew = acc; el = acc & e;
        ms_n = e ? 0 : (acc ? 1 : 2);
      end else begin
        if (ms == 1) begin ew = 1; el = e; end
        if (e && ms != 0) ms_n = 0;
      end
    end
    eline = blk ? 1'b1 : (cfg_rx_passthru ? rx_pin : ~rx_pin);
    @(negedge clk);
    chk({tag, " wr"}, fifo_wr, ew);
    chk({tag, " last"}, fifo_last, el);
    chk({tag, " discard"}, fifo_discard, edisc);
    if (ew) chk({tag, " data"}, fifo_data, d);
    chk(blk ? "R3 line" : "R2 line", rx_line, eline);
    ms = ms_n;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic frame(input logic [DW-1:0] addr, input int len, input string tag);
    step(1, 1, len == 1, addr, tag);
    for (int i = 1; i < len; i++) step(1, 0, i == len - 1, DW'($urandom), tag);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    rst_n = 0; rx_pin = 0; cfg_rx_passthru = 0; cfg_rx_disable = 0; tx_active = 0;
    cfg_match_en = 2'b00; cfg_addr1 = 8'h3C; cfg_addr2 = 8'hFF;
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 wr", fifo_wr, 0);
    chk("R1 discard", fifo_discard, 0);
    chk("R1 line", rx_line, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 wr after release", fifo_wr, 0);

    // R2 polarity, both settings
    rx_pin = 1; step(0, 0, 0, 0, "R2");
    rx_pin = 0; step(0, 0, 0, 0, "R2");
    cfg_rx_passthru = 1;
    rx_pin = 1; step(0, 0, 0, 0, "R2");
    rx_pin = 0; step(0, 0, 0, 0, "R2");
    cfg_rx_passthru = 0;
    // R3 blanking of the line
    cfg_rx_disable = 1; rx_pin = 1; step(0, 0, 0, 0, "R3");
    cfg_rx_disable = 0; tx_active = 1; rx_pin = 1; step(0, 0, 0, 0, "R3");
    tx_active = 0;

    // R4 open filter, includes a one-byte frame
    cfg_match_en = 2'b00;
    frame(8'h55, 4, "R4"); frame(8'h00, 1, "R4");
    // R5 address 1 only
    cfg_match_en = 2'b01;
    frame(8'h3C, 3, "R5"); frame(8'hFF, 3, "R5"); frame(8'h3D, 2, "R5");
    // R6 address 2 only
    cfg_match_en = 2'b10;
    frame(8'hFF, 3, "R6"); frame(8'h3C, 3, "R6");
    // R7 both
    cfg_match_en = 2'b11;
    frame(8'h3C, 2, "R7"); frame(8'hFF, 2, "R7"); frame(8'h7E, 2, "R7");
    // R8 rejected frame whose payload holds the addresses
    step(1, 1, 0, 8'h10, "R8"); step(1, 0, 0, 8'h3C, "R8");
    step(1, 0, 0, 8'hFF, "R8"); step(1, 0, 1, 8'h3C, "R8");
    // R9 orphan bytes
    step(1, 0, 0, 8'h3C, "R9"); step(1, 0, 1, 8'hFF, "R9");
    // R10 transmit starts inside an accepted frame
    step(1, 1, 0, 8'h3C, "R10"); step(1, 0, 0, 8'h11, "R10");
    tx_active = 1; step(1, 0, 0, 8'h22, "R10");
    tx_active = 0; step(1, 0, 0, 8'h33, "R10"); step(1, 0, 1, 8'h44, "R10");
    // R11 start flag while disabled
    cfg_rx_disable = 1; step(1, 1, 0, 8'h3C, "R11");
    cfg_rx_disable = 0; step(1, 0, 0, 8'h01, "R11"); step(1, 0, 1, 8'h02, "R11");
    // R12 new start inside an accepted frame, accepted and rejected restarts
    step(1, 1, 0, 8'hFF, "R12"); step(1, 0, 0, 8'h09, "R12");
    step(1, 1, 0, 8'h3C, "R12"); step(1, 0, 0, 8'h0A, "R12");
    step(1, 1, 0, 8'h99, "R12"); step(1, 0, 1, 8'h0B, "R12");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [DW-1:0] d;
      int pick;
      if ($urandom_range(0, 60) == 0) cfg_match_en = 2'($urandom);
      tx_active      = ($urandom_range(0, 30) == 0);
      cfg_rx_disable = ($urandom_range(0, 50) == 0);
      cfg_rx_passthru = ($urandom_range(0, 9) == 0);
      rx_pin = 1'($urandom);
      pick = $urandom_range(0, 3);
      d = (pick == 0) ? cfg_addr1 : (pick == 1) ? cfg_addr2 : DW'($urandom);
      step(($urandom_range(0, 4) != 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 4) == 0), d, "RND R8");
    end
    tx_active = 0; cfg_rx_disable = 0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule